// File: doc/BRIEF.md
# CPU Interrupt Interface With Priority Mask

This block sits between an interrupt distributor and one processor core. Each cycle the distributor offers the single best candidate interrupt as an identifier, an 8-bit priority value (numerically lower means more urgent) and a group bit. The block decides whether that candidate may interrupt the core, and raises either the IRQ or the FIQ request line.

Software reaches the block through a small word-addressed register port. It holds a control word that enables each group and chooses the request line for group 0, and a priority threshold. It also has an acknowledge location, where a read claims the pending interrupt, and a completion location, where a write of the ID retires the interrupt. Claimed interrupts are held on a running-priority stack, so only something more urgent than the work already in progress can nest on top of it.

Register map (addr_i): 0 = control, 1 = priority mask, 2 = acknowledge (read), 3 = end of interrupt (write). Reads return data combinationally in the cycle the read strobe is high; the side effects of reads and writes take place at the next rising clock edge.

Top module: `cpu_irq_if`

## Requirements
- R1: After reset, irq_o and fiq_o are low, the control and mask registers read 0, and an acknowledge read returns 1023.
- R2: A group 1 candidate (grp_i = 1) is signalled, always on irq_o, only while control bit 1 is set.
- R3: A group 0 candidate is signalled only while control bit 0 is set. It goes out on fiq_o when control bit 3 is set and on irq_o when that bit is clear. Bit 3 has no effect on group 1, and irq_o and fiq_o are never high together.
- R4: A candidate is signalled only when its priority is strictly below the mask register. A mask of 0x00 blocks every candidate, and a mask of 0xFF passes priorities 0x00 to 0xFE.
- R5: An acknowledge read returns the qualifying candidate's ID in bits 9:0 and marks it active. Both request lines are low in the cycle after that read.
- R6: When no candidate qualifies, an acknowledge read returns 1023 and changes no state.
- R7: A candidate is signalled only when its priority is strictly lower than the priority of the most recently acknowledged active interrupt. Up to 4 interrupts may be active at once, and with 4 active nothing is signalled.
- R8: Writing the ID of the most recently acknowledged active interrupt to the end-of-interrupt register retires it and restores the running priority of the interrupt below it, or no running priority when none remains.
- R9: An end-of-interrupt write whose ID does not match the most recently acknowledged active interrupt is ignored.
- R10: The request lines are registered. A change in candidate or configuration shows on irq_o and fiq_o one clock edge after it reaches the block's logic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cand_valid_i | input | 1 | Distributor offers a candidate |
| cand_id_i | input | 10 | Candidate interrupt ID |
| cand_prio_i | input | 8 | Candidate priority, lower is more urgent |
| cand_grp_i | input | 1 | Candidate group (0 or 1) |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data |
| irq_o | output | 1 | IRQ request to the core |
| fiq_o | output | 1 | FIQ request to the core |

## Verification
Assertions check these rules on every cycle: the two request lines are never high together, FIQ appears only with the enable set, a zero mask and a disabled group 1 both keep the lines low, the lines drop right after a claim, and spurious reads and mismatched completions leave the stack depth unchanged. The stack also asserts that it never pushes when full or pops when empty. Only the bench scenarios can show the values that software sees. These are the returned IDs, the strict comparisons at the mask and at the running-priority boundaries, and the correct restoring of earlier priorities when nested interrupts are completed in order.

// File: rtl/cpuif_pkg.sv
package cpuif_pkg;
  localparam int unsigned ID_W        = 10;
  localparam int unsigned PRIO_W      = 8;
  localparam int unsigned DATA_W      = 32;
  localparam int unsigned STACK_DEPTH = 4;
  localparam int unsigned SPURIOUS_ID = 1023;

  localparam int unsigned CTRL_W      = 4;
  localparam int unsigned CTRL_G0_EN  = 0;
  localparam int unsigned CTRL_G1_EN  = 1;
  localparam int unsigned CTRL_FIQ_EN = 3;
  localparam logic [CTRL_W-1:0] CTRL_WMASK = 4'b1011;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_PMR  = 2'd1,
    ADDR_ACK  = 2'd2,
    ADDR_EOI  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/cpuif_cfg_regs.sv
module cpuif_cfg_regs
  import cpuif_pkg::*;
#(
  parameter int unsigned PRIO_W = cpuif_pkg::PRIO_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic              pmr_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic [PRIO_W-1:0] pmr_wdata_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [PRIO_W-1:0] pmr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o <= '0;
      pmr_o  <= '0;
    end else begin
      if (ctrl_we_i) ctrl_o <= ctrl_wdata_i & CTRL_WMASK;
      if (pmr_we_i)  pmr_o  <= pmr_wdata_i;
    end
  end
endmodule

// File: rtl/cpuif_prio_stack.sv
module cpuif_prio_stack #(
  parameter int unsigned DEPTH  = 4,
  parameter int unsigned ID_W   = 10,
  parameter int unsigned PRIO_W = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [ID_W-1:0]   push_id_i,
  input  logic [PRIO_W-1:0] push_prio_i,
  output logic [ID_W-1:0]   top_id_o,
  output logic [PRIO_W:0]   top_prio_o,   // MSB set = idle (below every priority)
  output logic              empty_o,
  output logic              full_o,
  output logic [CNT_W-1:0]  count_o
);
  logic [ID_W-1:0]   id_q   [DEPTH];
  logic [PRIO_W-1:0] prio_q [DEPTH];
  logic [CNT_W-1:0]  cnt_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        id_q[g]   <= '0;
        prio_q[g] <= '0;
      end else if (push_i && cnt_q == CNT_W'(g)) begin
        id_q[g]   <= push_id_i;
        prio_q[g] <= push_prio_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (push_i && !full_o)  cnt_q <= cnt_q + 1'b1;
    else if (pop_i && !empty_o)  cnt_q <= cnt_q - 1'b1;
  end

  always_comb begin
    top_id_o   = '0;
    top_prio_o = {1'b1, {PRIO_W{1'b0}}};
    for (int i = 0; i < DEPTH; i++) begin
      if (cnt_q == CNT_W'(i + 1)) begin
        top_id_o   = id_q[i];
        top_prio_o = {1'b0, prio_q[i]};
      end
    end
  end

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign count_o = cnt_q;

  p_no_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  p_no_underflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
  p_push_raises_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i) |=> (top_prio_o == {1'b0, $past(push_prio_i)}));
endmodule

// File: rtl/cpuif_qualify.sv
module cpuif_qualify
  import cpuif_pkg::*;
#(
  parameter int unsigned PRIO_W = cpuif_pkg::PRIO_W
) (
  input  logic              cand_valid_i,
  input  logic [PRIO_W-1:0] cand_prio_i,
  input  logic              cand_grp_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic [PRIO_W-1:0] pmr_i,
  input  logic [PRIO_W:0]   running_i,
  input  logic              stack_full_i,
  output logic              qual_o,
  output logic              to_fiq_o
);
  logic grp_en, below_mask, above_running;

  assign grp_en        = cand_grp_i ? ctrl_i[CTRL_G1_EN] : ctrl_i[CTRL_G0_EN];
  assign below_mask    = cand_prio_i < pmr_i;
  assign above_running = {1'b0, cand_prio_i} < running_i;
  assign qual_o        = cand_valid_i && grp_en && below_mask && above_running && !stack_full_i;
  assign to_fiq_o      = !cand_grp_i && ctrl_i[CTRL_FIQ_EN];
endmodule

// File: rtl/cpu_irq_if.sv
module cpu_irq_if
  import cpuif_pkg::*;
#(
  parameter int unsigned ID_W        = cpuif_pkg::ID_W,
  parameter int unsigned PRIO_W      = cpuif_pkg::PRIO_W,
  parameter int unsigned DATA_W      = cpuif_pkg::DATA_W,
  parameter int unsigned STACK_DEPTH = cpuif_pkg::STACK_DEPTH,
  localparam int unsigned CNT_W      = $clog2(STACK_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cand_valid_i,
  input  logic [ID_W-1:0]   cand_id_i,
  input  logic [PRIO_W-1:0] cand_prio_i,
  input  logic              cand_grp_i,
  input  logic              reg_rd_i,
  input  logic              reg_wr_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic              fiq_o
);
  logic [CTRL_W-1:0] ctrl;
  logic [PRIO_W-1:0] pmr;
  logic [ID_W-1:0]   top_id;
  logic [PRIO_W:0]   running;
  logic              st_empty, st_full;
  logic [CNT_W-1:0]  depth;
  logic              qual, to_fiq;
  logic              ack_rd, eoi_wr, eoi_match, push, pop;
  reg_addr_e         addr;

  assign addr      = reg_addr_e'(reg_addr_i);
  assign ack_rd    = reg_rd_i && addr == ADDR_ACK;
  assign eoi_wr    = reg_wr_i && addr == ADDR_EOI;
  assign eoi_match = !st_empty && reg_wdata_i == DATA_W'(top_id);
  assign push      = ack_rd && qual;
  assign pop       = eoi_wr && eoi_match;

  cpuif_cfg_regs #(.PRIO_W(PRIO_W)) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ctrl_we_i    (reg_wr_i && addr == ADDR_CTRL),
    .pmr_we_i     (reg_wr_i && addr == ADDR_PMR),
    .ctrl_wdata_i (reg_wdata_i[CTRL_W-1:0]),
    .pmr_wdata_i  (reg_wdata_i[PRIO_W-1:0]),
    .ctrl_o       (ctrl),
    .pmr_o        (pmr)
  );

  cpuif_prio_stack #(.DEPTH(STACK_DEPTH), .ID_W(ID_W), .PRIO_W(PRIO_W)) u_stack (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .pop_i       (pop),
    .push_id_i   (cand_id_i),
    .push_prio_i (cand_prio_i),
    .top_id_o    (top_id),
    .top_prio_o  (running),
    .empty_o     (st_empty),
    .full_o      (st_full),
    .count_o     (depth)
  );

  cpuif_qualify #(.PRIO_W(PRIO_W)) u_qual (
    .cand_valid_i (cand_valid_i),
    .cand_prio_i  (cand_prio_i),
    .cand_grp_i   (cand_grp_i),
    .ctrl_i       (ctrl),
    .pmr_i        (pmr),
    .running_i    (running),
    .stack_full_i (st_full),
    .qual_o       (qual),
    .to_fiq_o     (to_fiq)
  );

  // a claimed candidate must not re-request in the following cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o <= 1'b0;
      fiq_o <= 1'b0;
    end else begin
      irq_o <= qual && !ack_rd && !to_fiq;
      fiq_o <= qual && !ack_rd &&  to_fiq;
    end
  end

  always_comb begin
    unique case (addr)
      ADDR_CTRL: reg_rdata_o = DATA_W'(ctrl);
      ADDR_PMR:  reg_rdata_o = DATA_W'(pmr);
      ADDR_ACK:  reg_rdata_o = qual ? DATA_W'(cand_id_i) : DATA_W'(SPURIOUS_ID);
      default:   reg_rdata_o = '0;
    endcase
  end

  p_one_line_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(irq_o && fiq_o));
  p_fiq_needs_en_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fiq_o |-> $past(ctrl[CTRL_FIQ_EN]));
  p_g1_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cand_grp_i && !ctrl[CTRL_G1_EN]) |=> (!irq_o && !fiq_o));
  p_pmr_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pmr == '0) |=> (!irq_o && !fiq_o));
  p_drop_after_ack_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_rd |=> (!irq_o && !fiq_o));
  p_spurious_stable_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_rd && !qual) |=> $stable(depth));
  p_eoi_mismatch_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_wr && !eoi_match) |=> $stable(depth));
endmodule

// File: tb/cpu_irq_if_tb.sv
`timescale 1ns/1ps
module cpu_irq_if_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cand_valid = 1'b0;
  logic [9:0]  cand_id = '0;
  logic [7:0]  cand_prio = '0;
  logic        cand_grp = 1'b0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, fiq;
  int          n_checks = 0, n_errors = 0;

  always #2 clk = ~clk;

  cpu_irq_if u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cand_valid_i(cand_valid), .cand_id_i(cand_id), .cand_prio_i(cand_prio), .cand_grp_i(cand_grp),
    .reg_rd_i(rd), .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .irq_o(irq), .fiq_o(fiq)
  );

  // {ctrl[3:0], pmr[7:0], grp, prio[7:0], exp_irq, exp_fiq}
  localparam logic [22:0] VEC [12] = '{
    {4'h2, 8'hFF, 1'b1, 8'h10, 1'b1, 1'b0},  // R2 g1 enabled
    {4'h0, 8'hFF, 1'b1, 8'h10, 1'b0, 1'b0},  // R2 g1 disabled
    {4'h1, 8'hFF, 1'b1, 8'h10, 1'b0, 1'b0},  // R2 only g0 enabled
    {4'h1, 8'hFF, 1'b0, 8'h10, 1'b1, 1'b0},  // R3 g0 on irq
    {4'h9, 8'hFF, 1'b0, 8'h10, 1'b0, 1'b1},  // R3 g0 on fiq
    {4'h8, 8'hFF, 1'b0, 8'h10, 1'b0, 1'b0},  // R3 g0 disabled
    {4'hB, 8'hFF, 1'b1, 8'h10, 1'b1, 1'b0},  // R3 fiq-en ignores g1
    {4'h3, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0},  // R4 zero mask
    {4'h3, 8'hFF, 1'b1, 8'hFE, 1'b1, 1'b0},  // R4 0xFE passes
    {4'h3, 8'hFF, 1'b1, 8'hFF, 1'b0, 1'b0},  // R4 0xFF blocked
    {4'h3, 8'h40, 1'b1, 8'h40, 1'b0, 1'b0},  // R4 equal blocked
    {4'h3, 8'h40, 1'b1, 8'h3F, 1'b1, 1'b0}   // R4 one below passes
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [31:0] d);
    rd = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic cand(input logic v, input logic [9:0] id, input logic [7:0] p, input logic g);
    cand_valid = v; cand_id = id; cand_prio = p; cand_grp = g;
    settle();
  endtask

  task automatic lines(input logic ei, input logic ef, input string req);
    check({30'd0, irq, fiq}, {30'd0, ei, ef}, req);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    lines(1'b0, 1'b0, "R1 lines");
    bus_rd(2'd0, d); check(d, 32'h0, "R1 ctrl");
    bus_rd(2'd1, d); check(d, 32'h0, "R1 pmr");
    bus_rd(2'd2, d); check(d, 32'd1023, "R1 ack");

    foreach (VEC[i]) begin
      bus_wr(2'd0, {28'd0, VEC[i][22:19]});
      bus_wr(2'd1, {24'd0, VEC[i][18:11]});
      cand(1'b1, 10'(i + 1), VEC[i][9:2], VEC[i][10]);
      lines(VEC[i][1], VEC[i][0], $sformatf("R2/R3/R4 vector %0d", i));
    end

    // R10 one-edge latency
    bus_wr(2'd0, 32'h3);
    bus_wr(2'd1, 32'hFF);
    cand(1'b0, 10'h0, 8'h0, 1'b1);
    cand_valid = 1'b1; cand_id = 10'h25; cand_prio = 8'h20;
    #1 lines(1'b0, 1'b0, "R10 before edge");
    @(posedge clk); #1 lines(1'b1, 1'b0, "R10 after edge");
    @(negedge clk);

    // R5 acknowledge
    bus_rd(2'd2, d); check(d, 32'h25, "R5 ack id");
    lines(1'b0, 1'b0, "R5 drop after ack");

    // R7 running priority
    cand(1'b1, 10'h26, 8'h20, 1'b1); lines(1'b0, 1'b0, "R7 equal to running");
    cand(1'b1, 10'h30, 8'h1F, 1'b1); lines(1'b1, 1'b0, "R7 above running");
    bus_rd(2'd2, d); check(d, 32'h30, "R7 nest 2");
    cand(1'b1, 10'h31, 8'h10, 1'b1);
    bus_rd(2'd2, d); check(d, 32'h31, "R7 nest 3");
    cand(1'b1, 10'h32, 8'h08, 1'b1);
    bus_rd(2'd2, d); check(d, 32'h32, "R7 nest 4");
    cand(1'b1, 10'h33, 8'h00, 1'b1); lines(1'b0, 1'b0, "R7 stack full");
    bus_rd(2'd2, d); check(d, 32'd1023, "R6 ack when full");

    // R8 / R9 completion order
    bus_wr(2'd3, 32'h32);
    cand(1'b1, 10'h40, 8'h09, 1'b1); lines(1'b1, 1'b0, "R8 restored to 0x10");
    cand(1'b1, 10'h40, 8'h10, 1'b1); lines(1'b0, 1'b0, "R8 equal to restored");
    bus_wr(2'd3, 32'h25); settle();
    lines(1'b0, 1'b0, "R9 mismatched eoi ignored");
    bus_wr(2'd3, 32'h31); settle();
    lines(1'b1, 1'b0, "R8 restored to 0x1F");
    cand(1'b1, 10'h40, 8'h1F, 1'b1); lines(1'b0, 1'b0, "R8 equal 0x1F");
    bus_wr(2'd3, 32'h30); settle();
    lines(1'b1, 1'b0, "R8 restored to 0x20");
    bus_wr(2'd3, 32'h25);
    cand(1'b1, 10'h41, 8'h20, 1'b1); lines(1'b1, 1'b0, "R8 stack empty");
    bus_wr(2'd3, 32'h41); settle();
    lines(1'b1, 1'b0, "R9 eoi on empty stack ignored");

    // R6 spurious leaves state alone
    cand(1'b0, 10'h41, 8'h20, 1'b1);
    bus_rd(2'd2, d); check(d, 32'd1023, "R6 no candidate");
    cand(1'b1, 10'h42, 8'hFE, 1'b1); lines(1'b1, 1'b0, "R6 nothing pushed");
    bus_wr(2'd1, 32'h10); settle();
    bus_rd(2'd2, d); check(d, 32'd1023, "R6 masked candidate");
    bus_wr(2'd1, 32'hFF); settle();
    lines(1'b1, 1'b0, "R6 state unchanged");

    // R3 fiq path clears on ack
    bus_wr(2'd0, 32'h9);
    cand(1'b1, 10'h50, 8'h05, 1'b0); lines(1'b0, 1'b1, "R3 fiq");
    bus_rd(2'd2, d); check(d, 32'h50, "R5 fiq ack");
    lines(1'b0, 1'b0, "R5 fiq drop");

    summary();
  end
endmodule